// File: doc/BRIEF.md
# Indirect Register Window (Index/Data Port Pair)

This block opens a small I/O-space window through which a host reaches a larger memory-mapped register space without mapping that space directly. The window holds two 32-bit registers. The pointer register keeps a dword-aligned byte address inside the register space. The data port sends each read or write to the register space at that address. A host first loads the pointer and then moves data through the data port as often as needed. The pointer stays where it was loaded until the host writes it again.

The I/O side is a single-cycle request interface: request strobe, byte offset, write enable and write data. Every read returns its data exactly one cycle later with a valid strobe. The register-space side is a master port. It issues one request per data-port access in the same cycle and takes read data back with a fixed one-cycle latency. Data passes through without any byte reordering, so bit n of the host word is bit n of the register word (little-endian). Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `idxwin_top`

## Requirements
- R1: While reset is held and after it is released, the pointer reads as zero and neither `io_rvalid` nor `m_req` is asserted until a request arrives.
- R2: A write at window offset 0x10 stores only bits 11:2 of the written value. Bits 1:0 and 31:12 of the pointer are always zero, so the stored value is `wdata & 0xFFC`.
- R3: A read at offset 0x10 returns the current pointer value on `io_rdata` one cycle after the request.
- R4: A read at offset 0x14 issues a master read at the pointer address in the request cycle. One cycle later `io_rdata` carries the word that the register space returned.
- R5: A write at offset 0x14 issues a master write in the request cycle. It carries the pointer address and the host write data, bit for bit and unchanged.
- R6: A read at any offset other than 0x10 or 0x14 (the window spans offsets 0..31) returns zero. A write there changes neither the pointer nor the register space.
- R7: The pointer never advances on its own. Repeated data-port accesses all target the same address until the pointer is rewritten.
- R8: `m_req` is high in exactly the cycles that carry a data-port request (`io_req` with offset 0x14), and in no other cycle.
- R9: `io_rvalid` is high exactly one cycle after each read request, at any offset, and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | I/O request strobe, one cycle per access |
| io_addr | input | 5 | Byte offset within the window |
| io_we | input | 1 | 1 = write, 0 = read |
| io_wdata | input | 32 | I/O write data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read request |
| io_rdata | output | 32 | I/O read data |
| m_req | output | 1 | Register-space request strobe |
| m_we | output | 1 | Register-space write enable |
| m_addr | output | 12 | Register-space byte address (dword aligned) |
| m_wdata | output | 32 | Register-space write data |
| m_rdata | input | 32 | Register-space read data, one cycle after a read request |

## Verification
Assertions check on every cycle that master requests appear only for data-port requests and never for other offsets. They also check that the pointer stays fixed unless it is being written, that read-valid follows exactly the read requests, and that a pointer read returns the pointer as it stood in the request cycle. Only the bench scenarios can show that the data reaching the register space lands at the right address and comes back unchanged. This is shown by write-then-read sequences against a shadow copy of the register space, by the masking of all-ones and random pointer values, and by the absence of any effect after writes to unused offsets.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_INDEX = 2'd1,
    SEL_DATA  = 2'd2
  } win_sel_e;
endpackage

// File: rtl/idxwin_rst_sync.sv
module idxwin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/idxwin_decode.sv
module idxwin_decode
  import idxwin_pkg::*;
#(
  parameter int WIN_AW  = 5,
  parameter int IDX_OFS = 16
) (
  input  logic              req,
  input  logic [WIN_AW-1:0] addr,
  output win_sel_e          sel
);
  localparam logic [WIN_AW-1:0] PTR_OFS  = WIN_AW'(IDX_OFS);
  localparam logic [WIN_AW-1:0] PORT_OFS = WIN_AW'(IDX_OFS + 4);

  always_comb begin
    sel = SEL_NONE;
    if (req) begin
      if (addr == PTR_OFS)       sel = SEL_INDEX;
      else if (addr == PORT_OFS) sel = SEL_DATA;
    end
  end
endmodule

// File: rtl/idxwin_index.sv
module idxwin_index #(
  parameter int DW     = 32,
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [REG_AW-1:0] idx
);
  localparam int KEEP_W = REG_AW - 2;

  logic [KEEP_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) ptr_d = wdata[REG_AW-1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_d;
  end

  assign idx = {ptr_q, 2'b00};

  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx));
endmodule

// File: rtl/idxwin_resp.sv
module idxwin_resp
  import idxwin_pkg::*;
#(
  parameter int DW     = 32,
  parameter int REG_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  win_sel_e          sel,
  input  logic [REG_AW-1:0] idx,
  input  logic [DW-1:0]     m_rdata,
  output logic              rvalid,
  output logic [DW-1:0]     rdata
);
  localparam int PAD_W = DW - REG_AW;

  logic          rvalid_q, rvalid_d;
  logic          from_m_q, from_m_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    rvalid_d = rd_strobe;
    from_m_d = rd_strobe && (sel == SEL_DATA);
    hold_d   = hold_q;
    if (rd_strobe) hold_d = (sel == SEL_INDEX) ? {{PAD_W{1'b0}}, idx} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      from_m_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      from_m_q <= from_m_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (rd_strobe) hold_q <= hold_d;
  end

  assign rvalid = rvalid_q;
  assign rdata  = !rvalid_q ? '0 : (from_m_q ? m_rdata : hold_q);

  p_idx_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && sel == SEL_INDEX) |=> (rdata == {{PAD_W{1'b0}}, $past(idx)}));
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
  import idxwin_pkg::*;
#(
  parameter int WIN_AW  = 5,
  parameter int REG_AW  = 12,
  parameter int DW      = 32,
  parameter int IDX_OFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic [WIN_AW-1:0] io_addr,
  input  logic              io_we,
  input  logic [DW-1:0]     io_wdata,
  output logic              io_rvalid,
  output logic [DW-1:0]     io_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [REG_AW-1:0] m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata
);
  localparam logic [WIN_AW-1:0] PTR_OFS  = WIN_AW'(IDX_OFS);
  localparam logic [WIN_AW-1:0] PORT_OFS = WIN_AW'(IDX_OFS + 4);

  logic              rst_i_n;
  win_sel_e          sel;
  logic [REG_AW-1:0] idx;
  logic              idx_wr;
  logic              rd_strobe;

  idxwin_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  idxwin_decode #(.WIN_AW(WIN_AW), .IDX_OFS(IDX_OFS)) u_dec (
    .req  (io_req),
    .addr (io_addr),
    .sel  (sel)
  );

  assign idx_wr    = (sel == SEL_INDEX) && io_we;
  assign rd_strobe = io_req && !io_we;

  idxwin_index #(.DW(DW), .REG_AW(REG_AW)) u_idx (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_en (idx_wr),
    .wdata (io_wdata),
    .idx   (idx)
  );

  idxwin_resp #(.DW(DW), .REG_AW(REG_AW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd_strobe (rd_strobe),
    .sel       (sel),
    .idx       (idx),
    .m_rdata   (m_rdata),
    .rvalid    (io_rvalid),
    .rdata     (io_rdata)
  );

  assign m_req   = (sel == SEL_DATA);
  assign m_we    = io_we;
  assign m_addr  = idx;
  assign m_wdata = io_wdata;

  p_mreq_decode_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    m_req |-> (io_req && io_addr == PORT_OFS));
  p_other_quiet_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_req && io_addr != PTR_OFS && io_addr != PORT_OFS) |-> !m_req);
  p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_req && !io_we) |=> io_rvalid);
  p_rvalid_only_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(io_req && !io_we) |=> !io_rvalid);
endmodule

// File: tb/idxwin_top_test.sv
module idxwin_top_test;
  logic        clk, rst_n;
  logic        io_req, io_we;
  logic [4:0]  io_addr;
  logic [31:0] io_wdata, io_rdata;
  logic        io_rvalid;
  logic        m_req, m_we;
  logic [11:0] m_addr;
  logic [31:0] m_wdata, m_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] regs   [1024];
  logic [31:0] shadow [1024];
  logic [31:0] model_idx;

  idxwin_top uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stand-in register space, one-cycle read latency
  always_ff @(posedge clk) begin
    if (m_req) begin
      if (m_we) regs[m_addr[11:2]] <= m_wdata;
      else      m_rdata <= regs[m_addr[11:2]];
    end
  end

  function automatic logic [31:0] init_val(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mask_ptr(input logic [31:0] v);
    return v & 32'h0000_0FFC;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [4:0] a, input logic we, input logic [31:0] wd);
    logic        exp_m;
    logic [31:0] exp_rd;
    string       tag;
    exp_m = (a == 5'h14);
    if (a == 5'h10)      begin exp_rd = model_idx;              tag = "R3"; end
    else if (a == 5'h14) begin exp_rd = shadow[model_idx[11:2]]; tag = "R4"; end
    else                 begin exp_rd = 32'h0;                  tag = "R6"; end
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_we = we; io_wdata = wd;
    #1;
    chk(m_req == exp_m, "R8 m_req", {31'b0, m_req}, {31'b0, exp_m});
    if (exp_m) begin
      chk(m_addr == model_idx[11:0], "R7 m_addr", {20'b0, m_addr}, model_idx);
      if (we) chk(m_we && m_wdata == wd, "R5 master write", m_wdata, wd);
      else    chk(!m_we, "R4 master read", {31'b0, m_we}, 32'h0);
    end
    @(negedge clk);
    io_req = 1'b0;
    chk(io_rvalid == !we, "R9 rvalid", {31'b0, io_rvalid}, {31'b0, !we});
    if (!we) chk(io_rdata == exp_rd, tag, io_rdata, exp_rd);
    if (we && a == 5'h10) model_idx = mask_ptr(wd);
    if (we && a == 5'h14) shadow[model_idx[11:2]] = wd;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(1234);
    for (int i = 0; i < 1024; i++) begin
      regs[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    model_idx = 32'h0;
    io_req = 1'b0; io_addr = '0; io_we = 1'b0; io_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_req && !io_rvalid, "R1 idle in reset", {30'b0, m_req, io_rvalid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!m_req && !io_rvalid, "R1 idle after reset", {30'b0, m_req, io_rvalid}, 32'h0);
    op(5'h10, 1'b0, 32'h0);                       // R1 pointer reads zero
    // R2 mask all-ones
    op(5'h10, 1'b1, 32'hFFFF_FFFF);
    op(5'h10, 1'b0, 32'h0);
    // R4 read, R5 write, R7 same address twice
    op(5'h10, 1'b1, 32'h0000_0123);
    op(5'h14, 1'b0, 32'h0);
    op(5'h14, 1'b0, 32'h0);
    op(5'h14, 1'b1, 32'hA5C3_0F81);
    op(5'h14, 1'b0, 32'h0);
    op(5'h10, 1'b0, 32'h0);                       // R7 pointer unchanged
    // R6 unused offsets: no effect
    op(5'h00, 1'b1, 32'hDEAD_BEEF);
    op(5'h11, 1'b1, 32'h0000_0040);
    op(5'h1F, 1'b1, 32'h1234_5678);
    op(5'h10, 1'b0, 32'h0);
    op(5'h14, 1'b0, 32'h0);
    op(5'h04, 1'b0, 32'h0);
    op(5'h18, 1'b0, 32'h0);
    // top boundary of register space
    op(5'h10, 1'b1, 32'h0000_0FFF);
    op(5'h14, 1'b1, 32'h0BAD_F00D);
    op(5'h14, 1'b0, 32'h0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int          pick;
      logic [4:0]  a;
      pick = int'($urandom_range(99));
      if (pick < 35)      a = 5'h10;
      else if (pick < 80) a = 5'h14;
      else                a = 5'($urandom_range(31));
      op(a, 1'($urandom_range(1)), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule